// File: doc/BRIEF.md
# Ring-Joint Coherence Directory Filter

This block sits where a group ring of caches joins the ring above it. It keeps a set-associative array of cacheline tags, each with a group-level state: absent, shared, or owned. Owned means the line is valid only inside this group, though several caches in the group may hold copies of it. The array holds no data. A coherence request can arrive from either ring. The block looks up the line, updates the group-level state, and sends the request on to exactly one of the two rings. Requests the group can serve stay on the group ring. Requests the group cannot serve climb to the upper ring. Requests from above enter the group only when the group holds the line.

After reset the block clears the array one set per cycle and accepts nothing until the sweep is done. Each request then takes a fixed three-phase pass: accept, lookup and decide, send. The result sits in an output register until the chosen ring takes it. A miss on a request that brings the line into the group allocates an entry. The first free way of the set is used. If the set is full, a per-set round-robin pointer chooses the victim. An instance at the top of the hierarchy has the same structure, and its upper port leads off chip.

Top module: `ring_dir_filter`

## Requirements
- R1: After reset, `in_ready` stays low while every set is cleared. Afterwards every line is absent, so an upper-ring request to any address goes to the upper port.
- R2: Each accepted request appears on exactly one output port. The request, port and valid stay unchanged until that port's ready is seen. `in_ready` is low while the output is pending.
- R3: A group read-shared request (op 0) that misses goes up and allocates the line as Shared. A group read-shared request that hits in either state goes to the group port with no state change.
- R4: A group read-exclusive request (op 1) or upgrade request (op 2) that hits an Owned line stays on the group port.
- R5: A group op 1 or op 2 request that hits Shared or misses goes up and leaves the line Owned.
- R6: An upper read-shared request that hits goes to the group port, and an Owned line becomes Shared.
- R7: An upper op 1 or op 2 request that hits goes to the group port and makes the line absent.
- R8: An upper request that misses, and any upper drop request (op 3), goes on along the upper port with no state change.
- R9: A group drop request (op 3) goes up, and a line that hits becomes absent.
- R10: On allocation the lowest-numbered free way of the set is used. In a full set the way at the set's round-robin pointer is replaced, and that pointer then advances by one with wrap-around.
- R11: A forwarded request carries the accepted source op and the full address unchanged. The set index is address bits [OFF_W +: SET_W], and the tag is the bits above the set index.
- R12: The output becomes valid exactly two clock edges after the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming request valid |
| in_ready | output | 1 | Block can accept a request |
| in_src | input | 1 | Arrival ring: 0 group, 1 upper |
| in_op | input | 2 | 0 read-shared, 1 read-exclusive, 2 upgrade, 3 drop |
| in_addr | input | ADDR_W | Byte address of the line |
| grp_valid | output | 1 | Request offered to the group ring |
| grp_ready | input | 1 | Group ring takes the request |
| grp_op | output | 2 | Op sent to the group ring |
| grp_addr | output | ADDR_W | Address sent to the group ring |
| up_valid | output | 1 | Request offered to the upper ring |
| up_ready | input | 1 | Upper ring takes the request |
| up_op | output | 2 | Op sent to the upper ring |
| up_addr | output | ADDR_W | Address sent to the upper ring |

## Verification
The bench checks state changes in pairs. A request that should change the state is followed by a probe whose route shows the new state. A design that failed to demote, or that invalidated the wrong way, would then route the probe to the wrong ring. The bench fills one set past its capacity and then revisits the lines in a chosen order. A victim choice that ignored free ways or froze the round-robin pointer would therefore keep the wrong tags resident. Back-pressure on the group port checks that the output holds steady and that no new request slips in. The sequence also includes an owned-line read-exclusive that must not climb, and an upper request to an absent line that must not allocate.

// File: rtl/dirf_pkg.sv
package dirf_pkg;
  typedef enum logic [1:0] {
    GS_NONE   = 2'd0,
    GS_SHARED = 2'd1,
    GS_OWNED  = 2'd2
  } grp_state_e;

  typedef enum logic [1:0] {
    OP_RDSH = 2'd0,
    OP_RDEX = 2'd1,
    OP_UPGR = 2'd2,
    OP_DROP = 2'd3
  } coh_op_e;

  localparam logic SRC_GROUP = 1'b0;
  localparam logic SRC_UPPER = 1'b1;
endpackage

// File: rtl/dirf_way_ram.sv
module dirf_way_ram #(
  parameter int W     = 10,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dirf_policy.sv
module dirf_policy
  import dirf_pkg::*;
(
  input  logic       src,
  input  coh_op_e    op,
  input  logic       hit,
  input  grp_state_e cur_st,
  output logic       to_upper,
  output logic       wr_en,
  output logic       alloc,
  output grp_state_e new_st
);
  always_comb begin
    to_upper = 1'b1;
    wr_en    = 1'b0;
    alloc    = 1'b0;
    new_st   = cur_st;
    if (src == SRC_GROUP) begin
      case (op)
        OP_RDSH: begin
          if (hit) to_upper = 1'b0;
          else begin
            alloc  = 1'b1;
            wr_en  = 1'b1;
            new_st = GS_SHARED;
          end
        end
        OP_RDEX, OP_UPGR: begin
          if (hit && cur_st == GS_OWNED) to_upper = 1'b0;
          else begin
            wr_en  = 1'b1;
            alloc  = !hit;
            new_st = GS_OWNED;
          end
        end
        default: begin
          if (hit) begin
            wr_en  = 1'b1;
            new_st = GS_NONE;
          end
        end
      endcase
    end else begin
      case (op)
        OP_RDSH: begin
          if (hit) begin
            to_upper = 1'b0;
            if (cur_st == GS_OWNED) begin
              wr_en  = 1'b1;
              new_st = GS_SHARED;
            end
          end
        end
        OP_RDEX, OP_UPGR: begin
          if (hit) begin
            to_upper = 1'b0;
            wr_en    = 1'b1;
            new_st   = GS_NONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dirf_victim.sv
module dirf_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_vec,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] way,
  output logic             all_full
);
  always_comb begin
    way = rr_ptr;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_vec[i]) way = WAY_W'(i);
    end
    all_full = &valid_vec;
  end
endmodule

// File: rtl/ring_dir_filter.sv
module ring_dir_filter
  import dirf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_src,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              grp_valid,
  input  logic              grp_ready,
  output logic [1:0]        grp_op,
  output logic [ADDR_W-1:0] grp_addr,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [1:0]        up_op,
  output logic [ADDR_W-1:0] up_addr
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT_W = TAG_W + 2;

  typedef enum logic [1:0] {PH_INIT, PH_IDLE, PH_LOOK, PH_SEND} phase_e;

  phase_e             phase;
  logic [SET_W-1:0]   init_cnt;
  logic               req_src;
  logic [1:0]         req_op;
  logic [ADDR_W-1:0]  req_addr;
  logic [WAY_W-1:0]   rr_ptr [SETS];

  logic [SET_W-1:0]   in_set, req_set, raddr, waddr;
  logic [TAG_W-1:0]   req_tag;
  logic [ENT_W-1:0]   rdata [WAYS];
  logic [ENT_W-1:0]   wdata;
  logic [WAYS-1:0]    valid_vec, hit_vec, we_vec;
  logic [WAY_W-1:0]   hit_way, vic_way, tgt_way;
  logic               hit, all_full;
  logic               pol_up, pol_wr, pol_alloc;
  grp_state_e         cur_st, new_st;

  assign in_set  = in_addr[OFF_W +: SET_W];
  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign raddr   = (phase == PH_IDLE) ? in_set : req_set;
  assign waddr   = (phase == PH_INIT) ? init_cnt : req_set;
  assign wdata   = (phase == PH_INIT) ? '0 : {req_tag, new_st};
  assign tgt_way = pol_alloc ? vic_way : hit_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign valid_vec[w] = rdata[w][1:0] != GS_NONE;
    assign hit_vec[w]   = valid_vec[w] && (rdata[w][ENT_W-1:2] == req_tag);
    assign we_vec[w]    = (phase == PH_INIT) ||
                          (phase == PH_LOOK && pol_wr && tgt_way == WAY_W'(w));
    dirf_way_ram #(.W(ENT_W), .DEPTH(SETS), .AW(SET_W)) i_ram (
      .clk   (clk),
      .we    (we_vec[w]),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata[w])
    );
  end

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
    end
  end
  assign hit    = |hit_vec;
  assign cur_st = grp_state_e'(rdata[hit_way][1:0]);

  dirf_policy i_policy (
    .src      (req_src),
    .op       (coh_op_e'(req_op)),
    .hit      (hit),
    .cur_st   (cur_st),
    .to_upper (pol_up),
    .wr_en    (pol_wr),
    .alloc    (pol_alloc),
    .new_st   (new_st)
  );

  dirf_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
    .valid_vec (valid_vec),
    .rr_ptr    (rr_ptr[req_set]),
    .way       (vic_way),
    .all_full  (all_full)
  );

  assign in_ready = (phase == PH_IDLE);
  assign grp_op   = req_op;
  assign grp_addr = req_addr;
  assign up_op    = req_op;
  assign up_addr  = req_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_INIT;
      init_cnt  <= '0;
      grp_valid <= 1'b0;
      up_valid  <= 1'b0;
      req_src   <= 1'b0;
      req_op    <= '0;
      req_addr  <= '0;
      for (int s = 0; s < SETS; s++) rr_ptr[s] <= '0;
    end else begin
      case (phase)
        PH_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == SET_W'(SETS - 1)) phase <= PH_IDLE;
        end
        PH_IDLE: begin
          if (in_valid) begin
            req_src  <= in_src;
            req_op   <= in_op;
            req_addr <= in_addr;
            phase    <= PH_LOOK;
          end
        end
        PH_LOOK: begin
          up_valid  <= pol_up;
          grp_valid <= !pol_up;
          if (pol_alloc && all_full) begin
            rr_ptr[req_set] <= (rr_ptr[req_set] == WAY_W'(WAYS - 1)) ?
                               '0 : rr_ptr[req_set] + 1'b1;
          end
          phase <= PH_SEND;
        end
        default: begin
          if ((grp_valid && grp_ready) || (up_valid && up_ready)) begin
            grp_valid <= 1'b0;
            up_valid  <= 1'b0;
            phase     <= PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dirf_checker.sv
module dirf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_op,
  input logic [ADDR_W-1:0] in_addr,
  input logic              grp_valid,
  input logic              grp_ready,
  input logic [1:0]        grp_op,
  input logic [ADDR_W-1:0] grp_addr,
  input logic              up_valid,
  input logic              up_ready,
  input logic [1:0]        up_op,
  input logic [ADDR_W-1:0] up_addr
);
  logic [1:0]        cap_op;
  logic [ADDR_W-1:0] cap_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op   <= '0;
      cap_addr <= '0;
    end else if (in_valid && in_ready) begin
      cap_op   <= in_op;
      cap_addr <= in_addr;
    end
  end

  a_r1_init_blocks: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !in_ready);

  a_r2_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grp_valid, up_valid}));

  a_r2_busy_no_accept: assert property (@(posedge clk) disable iff (rst)
    (grp_valid || up_valid) |-> !in_ready);

  a_r2_grp_hold: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && !grp_ready) |=> (grp_valid && $stable(grp_addr) && $stable(grp_op)));

  a_r2_up_hold: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_ready) |=> (up_valid && $stable(up_addr) && $stable(up_op)));

  a_r11_grp_payload: assert property (@(posedge clk) disable iff (rst)
    grp_valid |-> (grp_op == cap_op && grp_addr == cap_addr));

  a_r11_up_payload: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> (up_op == cap_op && up_addr == cap_addr));

  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 (grp_valid || up_valid));
endmodule

bind ring_dir_filter dirf_checker #(.ADDR_W(ADDR_W)) i_dirf_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_addr   (in_addr),
  .grp_valid (grp_valid),
  .grp_ready (grp_ready),
  .grp_op    (grp_op),
  .grp_addr  (grp_addr),
  .up_valid  (up_valid),
  .up_ready  (up_ready),
  .up_op     (up_op),
  .up_addr   (up_addr)
);

// File: tb/test_ring_dir_filter.sv
module test_ring_dir_filter;
  localparam int ADDR_W = 16;
  localparam bit GRP = 1'b0, UPR = 1'b1;
  localparam logic [1:0] RDSH = 2'd0, RDEX = 2'd1, UPGR = 2'd2, DROP = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_src = 1'b0;
  logic [1:0] in_op = '0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic in_ready, grp_valid, up_valid;
  logic grp_ready = 1'b1, up_ready = 1'b1;
  logic [1:0] grp_op, up_op;
  logic [ADDR_W-1:0] grp_addr, up_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ring_dir_filter i_ring_dir_filter (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_op(in_op), .in_addr(in_addr),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_op(grp_op), .grp_addr(grp_addr),
    .up_valid(up_valid), .up_ready(up_ready), .up_op(up_op), .up_addr(up_addr)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return {8'(tag), 4'(set), 4'h0};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // port code: 0 group, 1 upper, 2 none, 3 both
  function automatic int port_code();
    if (grp_valid && up_valid) return 3;
    if (up_valid) return 1;
    if (grp_valid) return 0;
    return 2;
  endfunction

  task automatic xfer(input bit src, input logic [1:0] op, input logic [ADDR_W-1:0] a,
                      input int exp_port, input string rq);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_src = src; in_op = op; in_addr = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(port_code() == 2, "R12 no early output", port_code(), 2);
    @(negedge clk);
    chk(port_code() == exp_port, rq, port_code(), exp_port);
    if (exp_port == 1)
      chk(up_addr == a && up_op == op, "R11 payload", int'(up_addr), int'(a));
    else
      chk(grp_addr == a && grp_op == op, "R11 payload", int'(grp_addr), int'(a));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b0, "R1 ready low in sweep", in_ready, 0);
    chk(port_code() == 2, "R1 outputs idle", port_code(), 2);
    xfer(UPR, RDSH, mk(3, 0), 1, "R1 absent after sweep");
    xfer(UPR, RDEX, mk(7, 15), 1, "R1 absent after sweep");
  endtask

  task automatic t_group_read();
    xfer(GRP, RDSH, mk(10, 1), 1, "R3 miss climbs");
    xfer(GRP, RDSH, mk(10, 1), 0, "R3 hit stays");
    xfer(GRP, RDSH, mk(10, 1), 0, "R3 repeat hit stays");
  endtask

  task automatic t_group_excl();
    xfer(GRP, RDSH, mk(11, 2), 1, "R3 miss climbs");
    xfer(GRP, RDEX, mk(11, 2), 1, "R5 shared needs upper");
    xfer(GRP, RDEX, mk(11, 2), 0, "R4 owned stays in group");
    xfer(GRP, UPGR, mk(11, 2), 0, "R4 owned upgrade stays");
    xfer(GRP, UPGR, mk(12, 2), 1, "R5 upgrade miss climbs");
    xfer(GRP, RDEX, mk(12, 2), 0, "R5 upgrade left owned");
  endtask

  task automatic t_upper_read();
    xfer(GRP, RDEX, mk(20, 3), 1, "R5 miss climbs");
    xfer(UPR, RDSH, mk(20, 3), 0, "R6 enters group");
    xfer(GRP, RDEX, mk(20, 3), 1, "R6 demoted to shared");
  endtask

  task automatic t_upper_excl();
    xfer(GRP, RDSH, mk(21, 4), 1, "R3 miss climbs");
    xfer(UPR, RDEX, mk(21, 4), 0, "R7 enters group");
    xfer(UPR, RDSH, mk(21, 4), 1, "R7 line now absent");
    xfer(GRP, RDEX, mk(22, 4), 1, "R5 miss climbs");
    xfer(UPR, UPGR, mk(22, 4), 0, "R7 upgrade enters group");
    xfer(GRP, RDSH, mk(22, 4), 1, "R7 line now absent");
  endtask

  task automatic t_upper_absent();
    xfer(UPR, RDEX, mk(30, 6), 1, "R8 absent stays upper");
    xfer(UPR, RDSH, mk(30, 6), 1, "R8 no allocation");
    xfer(GRP, RDEX, mk(31, 6), 1, "R5 miss climbs");
    xfer(UPR, DROP, mk(31, 6), 1, "R8 upper drop stays upper");
    xfer(GRP, RDEX, mk(31, 6), 0, "R8 drop left state owned");
  endtask

  task automatic t_group_drop();
    xfer(GRP, RDSH, mk(40, 7), 1, "R3 miss climbs");
    xfer(GRP, DROP, mk(40, 7), 1, "R9 drop climbs");
    xfer(GRP, RDSH, mk(40, 7), 1, "R9 line now absent");
    xfer(GRP, DROP, mk(41, 7), 1, "R9 drop miss climbs");
  endtask

  task automatic t_replace();
    for (int t = 1; t <= 5; t++) xfer(GRP, RDSH, mk(t, 9), 1, "R10 fill");
    for (int t = 2; t <= 5; t++) xfer(GRP, RDSH, mk(t, 9), 0, "R10 survivor hits");
    xfer(GRP, RDSH, mk(1, 9), 1, "R10 way0 victim");
    xfer(GRP, RDSH, mk(2, 9), 1, "R10 pointer advanced to way1");
    xfer(GRP, RDSH, mk(4, 9), 0, "R10 way3 kept");
    xfer(GRP, RDSH, mk(3, 9), 1, "R10 way2 victim");
  endtask

  task automatic t_backpressure();
    xfer(GRP, RDSH, mk(50, 10), 1, "R3 miss climbs");
    grp_ready = 1'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_src = GRP; in_op = RDSH; in_addr = mk(50, 10); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(port_code() == 0, "R2 held on group", port_code(), 0);
      chk(in_ready == 1'b0, "R2 busy blocks input", in_ready, 0);
      chk(grp_addr == mk(50, 10), "R2 address stable", int'(grp_addr), int'(mk(50, 10)));
      @(negedge clk);
    end
    grp_ready = 1'b1;
    @(negedge clk);
    chk(port_code() == 2, "R2 released after ready", port_code(), 2);
    chk(in_ready == 1'b1, "R2 ready returns", in_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_group_read();
    t_group_excl();
    t_upper_read();
    t_upper_excl();
    t_upper_absent();
    t_group_drop();
    t_replace();
    t_backpressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule